// File: doc/BRIEF.md
# Packet Classifying Input Arbiter

This block pulls whole packets out of one input FIFO and hands each packet to one of two downstream ports. Every FIFO entry is a 64-bit data word paired with an 8-bit control word. Control 0xFF marks the first word of a packet and 0x00 marks a middle word. The final word carries a one-hot control code that gives the position of its last valid byte; for example 0b01000000 means the valid data ends at data[63:48].

The choice of port depends on the EtherType, which is held in bits 31:16 of the second word. The block therefore reads the first two words into a small holding queue before it can send anything. If the field equals 0x0080, the packet goes to the control port. Any other value sends it to the bypass port. Words leave in their original order with their data and control unchanged.

Each output port has data, control, a valid strobe and a ready input. A word may be presented on a port only when that port's ready input was high at the previous clock edge, and the downstream logic takes every word that is marked valid. The FIFO is a standard one: the block raises a read enable, and the word appears on the FIFO outputs in the next cycle.

Top module: `pkt_class_arb`

## Requirements
- R1: While `rst` is high, `fifo_rd_en`, `ctl_valid` and `byp_valid` are all 0, even when the FIFO holds data.
- R2: `fifo_rd_en` is never high in a cycle in which `fifo_empty` is high.
- R3: When bits [31:16] of a packet's second word equal 16'h0080, the whole packet goes to the control port. Any other value, including 16'h0800, 16'h0081, 16'h8000 and 16'h86DD, sends the whole packet to the bypass port.
- R4: Every word of a packet appears exactly once on its port, with data and control unchanged and in FIFO order. The header word (control 0xFF) comes first.
- R5: A port's valid is high only in a cycle whose preceding clock edge saw that port's ready at 1. While the chosen port's ready stays 0, no more than two words of the packet are read from the FIFO before they are sent.
- R6: During a packet, the valid of the port that was not chosen stays 0. Valid is never high on both ports in the same cycle.
- R7: No word of a packet is sent before its second word has been read from the FIFO. If only the header is in the FIFO, both valids stay 0.
- R8: A packet ends at the first word after the header whose control is neither 0x00 nor 0xFF. The header of the next packet is read no earlier than the cycle in which the current packet's last word is valid on its port.
- R9: A two-word packet, whose second word carries the end code, is classified and sent in full.
- R10: While the chosen port's ready is held at 1 and the FIFO never runs empty, a packet of N words is valid on N consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_data | input | 64 | FIFO data word, valid the cycle after a read |
| fifo_ctrl | input | 8 | FIFO control word, valid the cycle after a read |
| fifo_empty | input | 1 | FIFO empty flag, active high |
| fifo_rd_en | output | 1 | FIFO read enable |
| ctl_data | output | 64 | Control port data |
| ctl_ctrl | output | 8 | Control port control word |
| ctl_valid | output | 1 | Control port word strobe |
| ctl_ready | input | 1 | Control port can accept a word |
| byp_data | output | 64 | Bypass port data |
| byp_ctrl | output | 8 | Bypass port control word |
| byp_valid | output | 1 | Bypass port word strobe |
| byp_ready | input | 1 | Bypass port can accept a word |

## Verification
Two events can fall in the same cycle. In one, the last word of a packet lands from the FIFO while the chosen port's ready is low, so the block must stop reading even though the next header is waiting. In the other, the holding queue receives a word and sends a word at once. The bench creates both by loading several back-to-back packets, toggling the two ready inputs pseudo-randomly and inserting FIFO empty gaps. It judges the result in two ways: the word stream on each port must match the expected stream exactly, and each time a header is read the number of words already sent must equal that header's position in the FIFO.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_HDR,
    ST_CLASSIFY,
    ST_FORWARD,
    ST_END_PKT
  } pa_state_e;

  localparam int NPORTS   = 2;
  localparam int PORT_CTL = 0;
  localparam int PORT_BYP = 1;
endpackage

// File: rtl/pa_hold_queue.sv
module pa_hold_queue #(
  parameter int W     = 72,
  parameter int DEPTH = 2,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_word,
  input  logic          pop,
  output logic [W-1:0]  head_word,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map to distributed or block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      level <= level + LW'(push) - LW'(pop);
    end
  end

  assign head_word = mem[rd_ptr];

  // R5: read-ahead never exceeds the holding capacity
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (int'(level) < DEPTH));

  // R4: a word is only sent when one is held
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> (level != '0));
endmodule

// File: rtl/pa_port_drive.sv
module pa_port_drive #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          req,
  input  logic          rdy,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_ctrl,
  output logic          take,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_ctrl
);
  assign take = sel && req && rdy;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= take;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= in_data;
      out_ctrl <= in_ctrl;
    end
  end

  // R5: a strobe follows an edge at which ready was high
  a_r5_valid_after_ready: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rdy));
endmodule

// File: rtl/pa_frame_ctl.sv
module pa_frame_ctl
  import pa_pkg::*;
#(
  parameter int CW       = 8,
  parameter int ET_W     = 16,
  parameter logic [ET_W-1:0] IP_ETYPE = 'h0080,
  parameter int QDEPTH   = 2,
  localparam int LW      = $clog2(QDEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fifo_empty,
  input  logic [CW-1:0]   land_ctrl,
  input  logic [ET_W-1:0] land_etype,
  input  logic [LW-1:0]   q_level,
  input  logic            emit,
  output logic            rd_en,
  output logic            land,
  output logic            send_req,
  output logic            sel_ip
);
  pa_state_e state;
  logic      land_last;
  int        level_after;

  // a landing word ends the packet when its code is neither middle nor header
  assign land_last = land && (land_ctrl != '0) && (land_ctrl != '1);

  always_comb level_after = int'(q_level) - (emit ? 1 : 0) + (land ? 1 : 0);

  always_comb begin
    rd_en = 1'b0;
    if (!rst && !fifo_empty) begin
      case (state)
        ST_IDLE:     rd_en = 1'b1;
        ST_READ_HDR: rd_en = 1'b1;
        ST_CLASSIFY: rd_en = !land;
        ST_FORWARD:  rd_en = !land_last && (level_after <= QDEPTH - 1);
        default:     rd_en = 1'b0;
      endcase
    end
  end

  assign send_req = ((state == ST_FORWARD) || (state == ST_END_PKT)) && (q_level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      land   <= 1'b0;
      sel_ip <= 1'b0;
    end else begin
      land <= rd_en;
      case (state)
        ST_IDLE:     if (rd_en) state <= ST_READ_HDR;
        ST_READ_HDR: state <= ST_CLASSIFY;
        ST_CLASSIFY: if (land) begin
                       sel_ip <= (land_etype == IP_ETYPE);
                       state  <= land_last ? ST_END_PKT : ST_FORWARD;
                     end
        ST_FORWARD:  if (land_last) state <= ST_END_PKT;
        ST_END_PKT:  if ((q_level == '0) || (emit && (q_level == LW'(1))))
                       state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  // R3: the port choice only moves while a packet is being classified
  a_r3_class_hold: assert property (@(posedge clk) disable iff (rst)
    (state != ST_CLASSIFY) |=> $stable(sel_ip));

  // R8: a new packet only starts once the previous one has fully drained
  a_r8_idle_drained: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (q_level == '0));
endmodule

// File: rtl/pkt_class_arb.sv
module pkt_class_arb
  import pa_pkg::*;
#(
  parameter int DW       = 64,
  parameter int CW       = 8,
  parameter int ET_LSB   = 16,
  parameter int ET_W     = 16,
  parameter logic [ET_W-1:0] IP_ETYPE = 'h0080,
  parameter int QDEPTH   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] fifo_data,
  input  logic [CW-1:0] fifo_ctrl,
  input  logic          fifo_empty,
  output logic          fifo_rd_en,
  output logic [DW-1:0] ctl_data,
  output logic [CW-1:0] ctl_ctrl,
  output logic          ctl_valid,
  input  logic          ctl_ready,
  output logic [DW-1:0] byp_data,
  output logic [CW-1:0] byp_ctrl,
  output logic          byp_valid,
  input  logic          byp_ready
);
  localparam int QW = DW + CW;
  localparam int LW = $clog2(QDEPTH + 1);

  logic              land, send_req, sel_ip, emit;
  logic [LW-1:0]     q_level;
  logic [QW-1:0]     head_word;
  logic [NPORTS-1:0] sel_v, rdy_v, take_v, vld_v;
  logic [DW-1:0]     od [NPORTS];
  logic [CW-1:0]     oc [NPORTS];

  pa_frame_ctl #(
    .CW(CW), .ET_W(ET_W), .IP_ETYPE(IP_ETYPE), .QDEPTH(QDEPTH)
  ) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .fifo_empty (fifo_empty),
    .land_ctrl  (fifo_ctrl),
    .land_etype (fifo_data[ET_LSB +: ET_W]),
    .q_level    (q_level),
    .emit       (emit),
    .rd_en      (fifo_rd_en),
    .land       (land),
    .send_req   (send_req),
    .sel_ip     (sel_ip)
  );

  pa_hold_queue #(.W(QW), .DEPTH(QDEPTH)) u_q (
    .clk       (clk),
    .rst       (rst),
    .push      (land),
    .push_word ({fifo_ctrl, fifo_data}),
    .pop       (emit),
    .head_word (head_word),
    .level     (q_level)
  );

  always_comb begin
    sel_v[PORT_CTL] = sel_ip;
    sel_v[PORT_BYP] = !sel_ip;
    rdy_v[PORT_CTL] = ctl_ready;
    rdy_v[PORT_BYP] = byp_ready;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    pa_port_drive #(.DW(DW), .CW(CW)) u_drv (
      .clk       (clk),
      .rst       (rst),
      .sel       (sel_v[p]),
      .req       (send_req),
      .rdy       (rdy_v[p]),
      .in_data   (head_word[DW-1:0]),
      .in_ctrl   (head_word[QW-1:DW]),
      .take      (take_v[p]),
      .out_valid (vld_v[p]),
      .out_data  (od[p]),
      .out_ctrl  (oc[p])
    );
  end

  assign emit      = |take_v;
  assign ctl_valid = vld_v[PORT_CTL];
  assign ctl_data  = od[PORT_CTL];
  assign ctl_ctrl  = oc[PORT_CTL];
  assign byp_valid = vld_v[PORT_BYP];
  assign byp_data  = od[PORT_BYP];
  assign byp_ctrl  = oc[PORT_BYP];

  // R6: one port strobes at a time
  a_r6_single_port: assert property (@(posedge clk) disable iff (rst)
    !(ctl_valid && byp_valid));

  // R6: control-port words only belong to packets classified as IP
  a_r6_ctl_matches_class: assert property (@(posedge clk) disable iff (rst)
    ctl_valid |-> sel_ip);
endmodule

// File: tb/sim_pkt_class_arb.sv
module sim_pkt_class_arb;
  localparam int DW = 64;
  localparam int CW = 8;
  localparam int FD = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [DW-1:0] fifo_data = '0;
  logic [CW-1:0] fifo_ctrl = '0;
  logic fifo_empty, fifo_rd_en;
  logic [DW-1:0] ctl_data, byp_data;
  logic [CW-1:0] ctl_ctrl, byp_ctrl;
  logic ctl_valid, byp_valid;
  logic ctl_ready = 1'b0, byp_ready = 1'b0;

  pkt_class_arb u0 (
    .clk(clk), .rst(rst), .fifo_data(fifo_data), .fifo_ctrl(fifo_ctrl),
    .fifo_empty(fifo_empty), .fifo_rd_en(fifo_rd_en),
    .ctl_data(ctl_data), .ctl_ctrl(ctl_ctrl), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .byp_data(byp_data), .byp_ctrl(byp_ctrl), .byp_valid(byp_valid), .byp_ready(byp_ready)
  );

  int checks = 0, errors = 0;

  // FIFO model: one-cycle read latency
  logic [DW-1:0] fm_data [FD];
  logic [CW-1:0] fm_ctrl [FD];
  logic          fm_hdr  [FD];
  int fill_ptr = 0, wr_ptr = 0, rd_ptr = 0;
  logic gap = 1'b0;
  assign fifo_empty = (rd_ptr == wr_ptr) || gap;

  always @(posedge clk) begin
    if (fifo_rd_en && !fifo_empty) begin
      fifo_data <= fm_data[rd_ptr];
      fifo_ctrl <= fm_ctrl[rd_ptr];
      rd_ptr    <= rd_ptr + 1;
    end
  end

  // stimulus for ready and FIFO gaps, applied just after each rising edge
  int rdy_mode = 0;
  logic gap_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: begin ctl_ready = 1'b1; byp_ready = 1'b1; end
      1: begin ctl_ready = 1'b0; byp_ready = 1'b0; end
      default: begin ctl_ready = lfsr[0]; byp_ready = lfsr[3]; end
    endcase
    gap = gap_mode ? (lfsr[5] & lfsr[7]) : 1'b0;
  end

  // scoreboard
  logic [CW+DW-1:0] exp_c [256], exp_b [256], cap_c [256], cap_b [256];
  int n_exp_c = 0, n_exp_b = 0, n_cap_c = 0, n_cap_b = 0, total_out = 0;
  int cyc = 0, ctl_first = -1, ctl_last = -1;
  logic prev_ctl_rdy = 1'b0, prev_byp_rdy = 1'b0, rd_empty_seen = 1'b0, wd_hit = 1'b0;

  always @(posedge clk) begin
    prev_ctl_rdy <= ctl_ready;
    prev_byp_rdy <= byp_ready;
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (ctl_valid) begin
        checks++;
        if (!prev_ctl_rdy) begin errors++; $display("FAIL R5 ctl valid act=1 exp=0 (ready was low)"); end
        if (n_cap_c < 256) cap_c[n_cap_c] = {ctl_ctrl, ctl_data};
        if (n_cap_c == 0) ctl_first = cyc;
        ctl_last = cyc;
        n_cap_c++; total_out++;
      end
      if (byp_valid) begin
        checks++;
        if (!prev_byp_rdy) begin errors++; $display("FAIL R5 byp valid act=1 exp=0 (ready was low)"); end
        if (n_cap_b < 256) cap_b[n_cap_b] = {byp_ctrl, byp_data};
        n_cap_b++; total_out++;
      end
      if (fifo_rd_en && fifo_empty) rd_empty_seen = 1'b1;
      if (fifo_rd_en && !fifo_empty && fm_hdr[rd_ptr]) begin
        checks++;
        if (total_out != rd_ptr) begin
          errors++;
          $display("FAIL R8 header read with words sent act=%0d exp=%0d", total_out, rd_ptr);
        end
      end
    end
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      errors++;
      $display("FAIL watchdog act=%0d cycles exp<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic add_pkt(input int len, input logic [15:0] et, input logic [7:0] endc, input int tag);
    for (int i = 0; i < len; i++) begin
      logic [DW-1:0] d;
      logic [CW-1:0] c;
      d = {8'(tag), 8'(i), 16'(tag * 37 + i * 11), 16'(i * 3 + 1), 16'hA5A5 ^ 16'(i)};
      if (i == 1) d[31:16] = et;
      c = (i == 0) ? 8'hFF : ((i == len - 1) ? endc : 8'h00);
      fm_data[fill_ptr] = d;
      fm_ctrl[fill_ptr] = c;
      fm_hdr[fill_ptr]  = (i == 0);
      if (et == 16'h0080) begin exp_c[n_exp_c] = {c, d}; n_exp_c++; end
      else                begin exp_b[n_exp_b] = {c, d}; n_exp_b++; end
      fill_ptr++;
    end
  endtask

  task automatic clear_sb();
    n_exp_c = 0; n_exp_b = 0; n_cap_c = 0; n_cap_b = 0;
    ctl_first = -1; ctl_last = -1;
  endtask

  task automatic wait_done(input int limit, input string req);
    int k = 0;
    while ((n_cap_c < n_exp_c || n_cap_b < n_exp_b) && k < limit) begin
      @(posedge clk); k++;
    end
    if (k >= limit) begin
      checks++; errors++;
      $display("FAIL %s timeout act=%0d/%0d words exp=%0d/%0d", req, n_cap_c, n_cap_b, n_exp_c, n_exp_b);
    end
    repeat (6) @(posedge clk);
  endtask

  task automatic compare(input string req);
    logic ok;
    int bad;
    ok = (n_cap_c == n_exp_c); bad = -1;
    for (int i = 0; i < n_exp_c && i < n_cap_c; i++)
      if (bad < 0 && cap_c[i] !== exp_c[i]) begin ok = 1'b0; bad = i; end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s ctl port count act=%0d exp=%0d word %0d act=%h exp=%h", req, n_cap_c, n_exp_c,
               bad, (bad >= 0) ? cap_c[bad] : '0, (bad >= 0) ? exp_c[bad] : '0);
    end
    ok = (n_cap_b == n_exp_b); bad = -1;
    for (int i = 0; i < n_exp_b && i < n_cap_b; i++)
      if (bad < 0 && cap_b[i] !== exp_b[i]) begin ok = 1'b0; bad = i; end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s byp port count act=%0d exp=%0d word %0d act=%h exp=%h", req, n_cap_b, n_exp_b,
               bad, (bad >= 0) ? cap_b[bad] : '0, (bad >= 0) ? exp_b[bad] : '0);
    end
  endtask

  task automatic check_eq(input int act, input int exp, input string msg);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
    end
  endtask

  // R1: quiet under reset although the FIFO holds a packet
  task automatic t_reset();
    clear_sb();
    add_pkt(3, 16'h0080, 8'h04, 1);
    wr_ptr = fill_ptr;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_eq(int'({fifo_rd_en, ctl_valid, byp_valid}), 0, "R1 outputs under reset");
    end
    @(posedge clk); #1 rst = 1'b0;
    wait_done(200, "R1");
    compare("R1 R4 first packet");
  endtask

  // R3 R4 R6 R10: IP packet streamed with ready held high
  task automatic t_ip_stream();
    clear_sb();
    add_pkt(6, 16'h0080, 8'h40, 2);
    wr_ptr = fill_ptr;
    wait_done(200, "R10");
    compare("R3 R4 ip stream");
    check_eq(n_cap_b, 0, "R6 bypass strobes during ip packet");
    check_eq(ctl_last - ctl_first + 1, 6, "R10 span of six-word packet");
  endtask

  // R3: near-miss type values all bypass
  task automatic t_class_edges();
    clear_sb();
    add_pkt(3, 16'h0800, 8'h80, 3);
    add_pkt(4, 16'h0081, 8'h01, 4);
    add_pkt(3, 16'h0080, 8'h02, 5);
    add_pkt(3, 16'h8000, 8'h10, 6);
    wr_ptr = fill_ptr;
    wait_done(300, "R3");
    compare("R3 type edges");
    check_eq(n_cap_b, 10, "R3 bypass word count");
  endtask

  // R9: two-word packets on both ports
  task automatic t_two_word();
    clear_sb();
    add_pkt(2, 16'h0080, 8'h20, 7);
    add_pkt(2, 16'h1234, 8'h08, 8);
    add_pkt(2, 16'h0080, 8'h01, 9);
    wr_ptr = fill_ptr;
    wait_done(300, "R9");
    compare("R9 two-word packets");
  endtask

  // R7: header alone never produces output
  task automatic t_header_only();
    int st;
    clear_sb();
    st = fill_ptr;
    add_pkt(4, 16'h0080, 8'h04, 10);
    wr_ptr = st + 1;
    repeat (20) @(posedge clk);
    check_eq(n_cap_c + n_cap_b, 0, "R7 words sent with header only");
    check_eq(rd_ptr - st, 1, "R7 words read with header only");
    wr_ptr = fill_ptr;
    wait_done(200, "R7");
    compare("R7 R4 after second word");
  endtask

  // R5 R8: blocked ports limit read-ahead; next packet waits for drain
  task automatic t_drain();
    int st;
    clear_sb();
    rdy_mode = 1;
    repeat (2) @(posedge clk);
    st = fill_ptr;
    add_pkt(3, 16'h0080, 8'h40, 11);
    add_pkt(3, 16'h0806, 8'h80, 12);
    wr_ptr = fill_ptr;
    repeat (30) @(posedge clk);
    check_eq(rd_ptr - st, 2, "R5 read-ahead while blocked");
    check_eq(n_cap_c + n_cap_b, 0, "R5 words sent while blocked");
    rdy_mode = 0;
    wait_done(200, "R8");
    compare("R8 R4 after unblock");
  endtask

  // R4 R5 R6: random ready on both ports with FIFO gaps
  task automatic t_stall();
    clear_sb();
    rdy_mode = 2;
    gap_mode = 1'b1;
    add_pkt(5, 16'h0080, 8'h02, 13);
    add_pkt(3, 16'h0800, 8'h40, 14);
    add_pkt(2, 16'h0080, 8'h80, 15);
    add_pkt(7, 16'h86DD, 8'h01, 16);
    add_pkt(4, 16'h0080, 8'h08, 17);
    add_pkt(3, 16'h0000, 8'h10, 18);
    wr_ptr = fill_ptr;
    wait_done(4000, "R5");
    compare("R4 R5 R6 random stall");
    rdy_mode = 0;
    gap_mode = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    t_reset();
    t_ip_stream();
    t_class_edges();
    t_two_word();
    t_header_only();
    t_drain();
    t_stall();
    check_eq(int'(rd_empty_seen), 0, "R2 read while empty");
    check_eq(rd_ptr, fill_ptr, "R4 all FIFO words consumed");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule